// File: doc/BRIEF.md
# Compare-and-Branch Fusion Detector

This decode-stage unit inspects a small window of instruction slots, held in program order, and marks the places where a flag-producing instruction can merge with the conditional jump that directly follows it. Each slot carries a valid bit, a two-bit opcode class and a four-bit condition code. When a pair fuses, the producer slot is flagged to fuse with its successor, the jump slot is flagged as consumed, and a fused-operation record is written at the producer slot. The record holds the producer type, the jump condition and the index of the jump slot.

Eligibility depends on two things. The first is the kind of producer: a bit test fuses with any jump, while an arithmetic compare fuses only with jumps that read the carry and zero flags alone. The second is a generation setting: the older generation refuses every fusion while the core runs in 64-bit mode. Pairing is resolved left to right across the window. All outputs are registered, so results appear one clock after the window is presented. The unit also reports how many operations the window emits after fusion.

Top module: `fuse_detect`

## Requirements
- R1: A pair fuses only when slot i is valid with class TEST (1) or CMP (2) and slot i+1 is valid with class JCC (3). Class OTHER is 0. A gap slot of any class, or an invalid slot, between producer and jump prevents fusion.
- R2: A TEST directly followed by a JCC fuses for all 16 condition codes.
- R3: A CMP directly followed by a JCC fuses when the jump's condition code is 2 through 7. These are the carry/zero tests: below, not-below, equal, not-equal, below-or-equal and above.
- R4: A CMP directly followed by a JCC with condition code 0, 1 or 8 through 15 does not fuse. Neither slot is flagged, and both count as separate operations.
- R5: With newGen low and longMode high, no slot fuses. With newGen high, longMode has no effect on fusion.
- R6: For a fused pair, fuseNext is set at the producer slot and consumed is set at the jump slot. opCount equals the number of valid slots minus the number of fused pairs.
- R7: Pairing runs from slot 0 upward, and a slot consumed as a jump never starts a pair. Several disjoint pairs in one window all fuse.
- R8: A TEST or CMP in the last slot never fuses.
- R9: At a fused producer slot, the record gives recIsCmp (1 for CMP, 0 for TEST), the jump's condition code in recCond, and the jump slot index in recBranchIdx. At slots that do not fuse, these fields are zero.
- R10: Outputs follow the inputs presented before the previous rising edge, one cycle later. A synchronous reset clears outValid, fuseNext, consumed, the record fields and opCount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slotValid | input | 4 | Per-slot valid bit |
| slotClass | input | 8 | Per-slot opcode class, 2 bits per slot, slot i at [2i+1:2i] |
| slotCond | input | 16 | Per-slot condition code, 4 bits per slot, slot i at [4i+3:4i] |
| longMode | input | 1 | Core is in 64-bit mode |
| newGen | input | 1 | Selects the newer generation, which allows fusion in 64-bit mode |
| outValid | output | 4 | Registered slot valid bits |
| fuseNext | output | 4 | Slot fuses with the slot after it |
| consumed | output | 4 | Slot was absorbed as the jump of a fused pair |
| recIsCmp | output | 4 | Fused record: producer was CMP (1) or TEST (0) |
| recCond | output | 16 | Fused record: jump condition code, 4 bits per slot |
| recBranchIdx | output | 8 | Fused record: jump slot index, 2 bits per slot |
| opCount | output | 3 | Operations emitted by the window after fusion |

## Verification
The bench sweeps every pairing of producer class and follower class against all 16 condition codes, under both mode values and both generation settings. A design that widened or narrowed the compare condition range by one code, or that ignored the generation setting in 64-bit mode, would flip the fuse flag for whole blocks of this sweep. Directed windows cover the remaining corners. A compare separated from its jump by another instruction or by an invalid slot must stay unfused; a design that looked across the gap would fuse it. A compare in the last slot must stay unfused; a design that assumed a successor would flag it. Back-to-back disjoint pairs must both fuse; a design that let one pair suppress the next would lose the second fusion and give a wrong operation count and wrong record indices.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  parameter int SLOTS = 4;
  parameter int CC_W = 4;
  parameter int CLS_W = 2;
  localparam int IDX_W = $clog2(SLOTS);
  localparam int CNT_W = $clog2(SLOTS + 1);

  typedef enum logic [CLS_W-1:0] {
    CLS_OTHER = 2'd0,
    CLS_TEST  = 2'd1,
    CLS_CMP   = 2'd2,
    CLS_JCC   = 2'd3
  } opClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [SLOTS-1:0] fuseAt;
    logic [SLOTS-1:0] takeAt;
    logic             modeBlock;
  } fuseStrb_t;
endpackage

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
  import fuse_pkg::*;
(
  input  logic [SLOTS-1:0]       slotValid,
  input  logic [SLOTS*CLS_W-1:0] slotClass,
  input  logic [SLOTS*CC_W-1:0]  slotCond,
  input  logic                   longMode,
  input  logic                   newGen,
  output fuseStrb_t              strb
);
  logic [SLOTS-1:0] pairOk;
  logic             blockAll;

  function automatic logic cmpCondOk(input logic [CC_W-1:0] cc);
    return (cc >= CC_W'(2)) && (cc <= CC_W'(7));
  endfunction

  assign blockAll = longMode && !newGen;

  genvar gi;
  generate
    for (gi = 0; gi < SLOTS - 1; gi++) begin : g_pair
      logic [CLS_W-1:0] headCls;
      logic [CLS_W-1:0] tailCls;
      logic [CC_W-1:0]  tailCc;
      assign headCls = slotClass[gi*CLS_W +: CLS_W];
      assign tailCls = slotClass[(gi+1)*CLS_W +: CLS_W];
      assign tailCc  = slotCond[(gi+1)*CC_W +: CC_W];
      assign pairOk[gi] = slotValid[gi] && slotValid[gi+1] && !blockAll &&
                          (tailCls == CLS_JCC) &&
                          ((headCls == CLS_TEST) ||
                           ((headCls == CLS_CMP) && cmpCondOk(tailCc)));
    end
  endgenerate
  assign pairOk[SLOTS-1] = 1'b0;

  // left-to-right resolution: a slot taken as a branch cannot start a pair
  always_comb begin
    logic busy;
    busy = 1'b0;
    strb.fuseAt = '0;
    strb.takeAt = '0;
    for (int i = 0; i < SLOTS; i++) begin
      strb.takeAt[i] = busy;
      strb.fuseAt[i] = pairOk[i] && !busy;
      busy = strb.fuseAt[i];
    end
    strb.modeBlock = blockAll;
  end
endmodule

// File: rtl/fuse_dpath.sv
module fuse_dpath
  import fuse_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  fuseStrb_t              strb,
  input  logic [SLOTS-1:0]       slotValid,
  input  logic [SLOTS*CLS_W-1:0] slotClass,
  input  logic [SLOTS*CC_W-1:0]  slotCond,
  output logic [SLOTS-1:0]       outValid,
  output logic [SLOTS-1:0]       fuseNext,
  output logic [SLOTS-1:0]       consumed,
  output logic [SLOTS-1:0]       recIsCmp,
  output logic [SLOTS*CC_W-1:0]  recCond,
  output logic [SLOTS*IDX_W-1:0] recBranchIdx,
  output logic [CNT_W-1:0]       opCount
);
  logic [SLOTS-1:0]       nxtIsCmp;
  logic [SLOTS*CC_W-1:0]  nxtCond;
  logic [SLOTS*IDX_W-1:0] nxtIdx;
  logic [CNT_W-1:0]       nValid;
  logic [CNT_W-1:0]       nFuse;

  always_comb begin
    nxtIsCmp = '0;
    nxtCond  = '0;
    nxtIdx   = '0;
    nValid   = '0;
    nFuse    = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (slotValid[i]) nValid = nValid + CNT_W'(1);
      if (strb.fuseAt[i]) begin
        nFuse = nFuse + CNT_W'(1);
        nxtIsCmp[i] = (slotClass[i*CLS_W +: CLS_W] == CLS_CMP);
        if (i < SLOTS - 1) begin
          nxtCond[i*CC_W +: CC_W] = slotCond[(i+1)*CC_W +: CC_W];
          nxtIdx[i*IDX_W +: IDX_W] = IDX_W'(i + 1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid     <= '0;
      fuseNext     <= '0;
      consumed     <= '0;
      recIsCmp     <= '0;
      recCond      <= '0;
      recBranchIdx <= '0;
      opCount      <= '0;
    end else begin
      outValid     <= slotValid;
      fuseNext     <= strb.fuseAt;
      consumed     <= strb.takeAt;
      recIsCmp     <= nxtIsCmp;
      recCond      <= nxtCond;
      recBranchIdx <= nxtIdx;
      opCount      <= nValid - nFuse;
    end
  end

  // R8
  last_no_fuse_chk: assert property (@(posedge clk) disable iff (rst)
    !fuseNext[SLOTS-1]);

  // R6
  first_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
    !consumed[0]);

  // R6
  op_count_chk: assert property (@(posedge clk) disable iff (rst)
    32'(opCount) == $countones(outValid) - $countones(fuseNext));

  genvar gj;
  generate
    for (gj = 1; gj < SLOTS; gj++) begin : g_chk
      // R6
      taken_after_fuse_chk: assert property (@(posedge clk) disable iff (rst)
        consumed[gj] |-> (fuseNext[gj-1] && outValid[gj] && outValid[gj-1]));
      // R7
      no_chain_chk: assert property (@(posedge clk) disable iff (rst)
        consumed[gj] |-> !fuseNext[gj]);
    end
    for (gj = 0; gj < SLOTS; gj++) begin : g_cond
      // R3
      cmp_cond_chk: assert property (@(posedge clk) disable iff (rst)
        (fuseNext[gj] && recIsCmp[gj]) |->
          (recCond[gj*CC_W +: CC_W] >= CC_W'(2) && recCond[gj*CC_W +: CC_W] <= CC_W'(7)));
    end
  endgenerate
endmodule

// File: rtl/fuse_detect.sv
module fuse_detect
  import fuse_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SLOTS-1:0]       slotValid,
  input  logic [SLOTS*CLS_W-1:0] slotClass,
  input  logic [SLOTS*CC_W-1:0]  slotCond,
  input  logic                   longMode,
  input  logic                   newGen,
  output logic [SLOTS-1:0]       outValid,
  output logic [SLOTS-1:0]       fuseNext,
  output logic [SLOTS-1:0]       consumed,
  output logic [SLOTS-1:0]       recIsCmp,
  output logic [SLOTS*CC_W-1:0]  recCond,
  output logic [SLOTS*IDX_W-1:0] recBranchIdx,
  output logic [CNT_W-1:0]       opCount
);
  fuseStrb_t strb;

  fuse_ctrl ctrl_i (
    .slotValid (slotValid),
    .slotClass (slotClass),
    .slotCond  (slotCond),
    .longMode  (longMode),
    .newGen    (newGen),
    .strb      (strb)
  );

  fuse_dpath dpath_i (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .slotValid    (slotValid),
    .slotClass    (slotClass),
    .slotCond     (slotCond),
    .outValid     (outValid),
    .fuseNext     (fuseNext),
    .consumed     (consumed),
    .recIsCmp     (recIsCmp),
    .recCond      (recCond),
    .recBranchIdx (recBranchIdx),
    .opCount      (opCount)
  );

  // R5
  legacy_long_block_chk: assert property (@(posedge clk) disable iff (rst)
    (longMode && !newGen) |=> (fuseNext == '0 && consumed == '0));
endmodule

// File: tb/fuse_detect_tb_top.sv
module fuse_detect_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int S = 4;
  localparam int IW = 2;
  localparam int CW = 3;

  typedef struct {
    logic [S-1:0]    v;
    logic [S-1:0]    f;
    logic [S-1:0]    c;
    logic [S-1:0]    ic;
    logic [4*S-1:0]  cond;
    logic [IW*S-1:0] idx;
    logic [CW-1:0]   cnt;
    string           tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [S-1:0]    slotValid = '0;
  logic [2*S-1:0]  slotClass = '0;
  logic [4*S-1:0]  slotCond = '0;
  logic            longMode = 1'b0;
  logic            newGen = 1'b0;
  logic [S-1:0]    outValid, fuseNext, consumed, recIsCmp;
  logic [4*S-1:0]  recCond;
  logic [IW*S-1:0] recBranchIdx;
  logic [CW-1:0]   opCount;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_detect dut_i (
    .clk(clk), .rst(rst), .slotValid(slotValid), .slotClass(slotClass),
    .slotCond(slotCond), .longMode(longMode), .newGen(newGen),
    .outValid(outValid), .fuseNext(fuseNext), .consumed(consumed),
    .recIsCmp(recIsCmp), .recCond(recCond), .recBranchIdx(recBranchIdx),
    .opCount(opCount)
  );

  function automatic exp_t model(logic [S-1:0] v, logic [2*S-1:0] cl,
                                 logic [4*S-1:0] cd, logic lm, logic ng);
    exp_t e;
    int fusions;
    int nv;
    fusions = 0;
    nv = 0;
    e.v = v; e.f = '0; e.c = '0; e.ic = '0; e.cond = '0; e.idx = '0;
    e.tag = "";
    for (int i = 0; i < S - 1; i++) begin
      logic [1:0] first;
      logic [3:0] ccv;
      logic ok;
      first = cl[2*i +: 2];
      ccv = cd[4*(i+1) +: 4];
      ok = (first == 2'd1) || (first == 2'd2 && ccv >= 4'd2 && ccv <= 4'd7);
      if (!e.c[i] && v[i] && v[i+1] && cl[2*(i+1) +: 2] == 2'd3 && (!lm || ng) && ok) begin
        e.f[i] = 1'b1;
        e.c[i+1] = 1'b1;
        e.ic[i] = (first == 2'd2);
        e.cond[4*i +: 4] = ccv;
        e.idx[IW*i +: IW] = IW'(i + 1);
        fusions++;
      end
    end
    for (int i = 0; i < S; i++) if (v[i]) nv++;
    e.cnt = CW'(nv - fusions);
    return e;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic drive(logic [S-1:0] v, logic [2*S-1:0] cl, logic [4*S-1:0] cd,
                       logic lm, logic ng, string tag);
    exp_t e;
    @(negedge clk);
    #1;
    slotValid = v; slotClass = cl; slotCond = cd; longMode = lm; newGen = ng;
    e = model(v, cl, cd, lm, ng);
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: items pushed one cycle earlier are due now (R10 latency)
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R10", "outValid", 32'(outValid), 32'(e.v));
      chk(e.tag, "fuseNext", 32'(fuseNext), 32'(e.f));
      chk(e.tag, "consumed", 32'(consumed), 32'(e.c));
      chk("R9", "recIsCmp", 32'(recIsCmp), 32'(e.ic));
      chk("R9", "recCond", 32'(recCond), 32'(e.cond));
      chk("R9", "recBranchIdx", 32'(recBranchIdx), 32'(e.idx));
      chk("R6", "opCount", 32'(opCount), 32'(e.cnt));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset must win over a fusable window
    slotValid = '1;
    slotClass = {2'd3, 2'd1, 2'd3, 2'd1};
    slotCond = 16'h4444;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "reset outValid", 32'(outValid), 32'd0);
    chk("R10", "reset fuseNext", 32'(fuseNext), 32'd0);
    chk("R10", "reset consumed", 32'(consumed), 32'd0);
    chk("R10", "reset opCount", 32'(opCount), 32'd0);
    #1 rst = 1'b0;

    // exhaustive sweep with the pair at slots 1 and 2
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int cc = 0; cc < 16; cc++)
          for (int m = 0; m < 4; m++) begin
            logic lm, ng;
            string tag;
            lm = m[0]; ng = m[1];
            if (!(a >= 1 && a <= 2 && b == 3)) tag = "R1";
            else if (lm && !ng) tag = "R5";
            else if (a == 1) tag = "R2";
            else if (cc >= 2 && cc <= 7) tag = "R3";
            else tag = "R4";
            drive(4'b1111, {2'd0, 2'(b), 2'(a), 2'd0},
                  {4'h9, 4'(cc), 4'(15 - cc), 4'(cc)}, lm, ng, tag);
          end

    // R1: compare, other, jump must not fuse across the gap
    drive(4'b1111, {2'd0, 2'd3, 2'd0, 2'd2}, 16'h0400, 1'b0, 1'b0, "R1");
    // R1: invalid slot between test and jump
    drive(4'b1101, {2'd0, 2'd3, 2'd3, 2'd1}, 16'h0440, 1'b0, 1'b1, "R1");
    // R8: compare and test in the last slot stay unfused
    drive(4'b1111, {2'd2, 2'd0, 2'd0, 2'd0}, 16'h0000, 1'b0, 1'b0, "R8");
    drive(4'b1111, {2'd1, 2'd0, 2'd0, 2'd0}, 16'h0000, 1'b1, 1'b1, "R8");
    // R7: two disjoint pairs in one window
    drive(4'b1111, {2'd3, 2'd2, 2'd3, 2'd1}, 16'h5080, 1'b0, 1'b0, "R7");
    // R7: jump, jump, test, jump: only the last pair fuses (record index 3)
    drive(4'b1111, {2'd3, 2'd1, 2'd3, 2'd3}, 16'hC000, 1'b1, 1'b1, "R7");
    // R5: same window under legacy generation in 64-bit mode
    drive(4'b1111, {2'd3, 2'd2, 2'd3, 2'd1}, 16'h5080, 1'b1, 1'b0, "R5");
    // R6: sparse valid window with one fusion
    drive(4'b0011, {2'd0, 2'd0, 2'd3, 2'd2}, 16'h0030, 1'b0, 1'b0, "R6");

    drive(4'b0000, '0, '0, 1'b0, 1'b0, "R10");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule